// File: doc/BRIEF.md
# Mode-Dependent Multiplexed GPIO Port

This block is an 8-bit I/O port. It holds two registers on a small register bus: an output latch and a per-pin direction mask. A two-bit operating-mode input decides who owns the pins. In single-chip mode every pin is ordinary general-purpose I/O. In every other mode the lower seven pins carry the upper external address bits (bits 22 down to 16), and the top pin becomes a wait or ROM-control input. When internal visibility is on in the emulation or special-test mode, some of the address pins take turns with status signals. A phase input picks which of the two signal sets is on the pins.

In emulation mode the port forwards every register write to an external bus port in the same cycle, and the internal register is also updated. Register reads in that mode return the value that the external bus supplies. Outside emulation, a read of the data register merges two sources: the latch bit on output pins and the live pin level on input pins. Tri-state control leaves the block as one output-enable bit per pin.

Top module: `mpx_port`

## Requirements
- R1: After reset both registers hold zero. In single-chip mode all output enables are 0, a direction read returns 0x00, and a data read returns `pin_in`.
- R2: In single-chip mode, `pin_oe` equals the direction register and `pin_out` equals the data register. A direction bit of 1 makes its pin an output.
- R3: Outside emulation mode, a data read (`bus_sel`=0) returns, for each bit, the latch bit when the direction bit is 1 and the `pin_in` bit when the direction bit is 0.
- R4: Outside emulation mode, a direction read (`bus_sel`=1) returns the direction register.
- R5: In emulation mode (`mode`=2), reads of either register return `ext_rd_data`.
- R6: In emulation mode, a write drives `ext_wr_en`=1, `ext_wr_sel`=`bus_sel` and `ext_wr_data`=`bus_wdata` in the same cycle. The internal register is also updated.
- R7: In any mode other than emulation, `ext_wr_en` stays 0, even during register writes.
- R8: In modes 1, 2 and 3 (expanded, emulation, special test), `pin_out[6:0]` carries `ext_addr`. Bits 6:0 of `pin_oe` are forced to 1 whatever the direction register holds.
- R9: In modes 2 or 3 with `vis_en`=1 and `phase`=1, pin 6 carries `noacc` and pins 3:0 carry `iq_stat`, while pins 5:4 keep `ext_addr[5:4]`. With `phase`=0 the pins carry `ext_addr`.
- R10: In mode 1, `vis_en` and `phase` have no effect on the pins: `ext_addr` is driven.
- R11: In modes 1, 2 and 3, pin 7 is an input (`pin_oe[7]`=0), and `pin7_wait` follows `pin_in[7]`. In single-chip mode pin 7 is ordinary GPIO.
- R12: Both registers accept writes in every mode. A value written while the pins are not owned by GPIO reads back after a return to single-chip mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 single-chip, 1 expanded, 2 emulation, 3 special test |
| vis_en | input | 1 | Internal visibility enable |
| phase | input | 1 | Multiplex phase: 0 address, 1 status |
| bus_sel | input | 1 | Register select: 0 data, 1 direction |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| ext_rd_data | input | 8 | Read value supplied by the external bus in emulation mode |
| ext_wr_en | output | 1 | Mirrored write strobe |
| ext_wr_sel | output | 1 | Mirrored register select |
| ext_wr_data | output | 8 | Mirrored write data |
| ext_addr | input | 7 | External address bits 22..16 |
| noacc | input | 1 | No-access flag |
| iq_stat | input | 4 | Instruction-queue status |
| pin_in | input | 8 | Buffered pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Per-pin output enables |
| pin7_wait | output | 1 | Pin 7 level forwarded as the wait/ROM-control input |

## Verification
The direction register is the most likely state to go wrong. An error there shows at once on `pin_oe` in single-chip mode. It also shows in the very next combinational data read, because the latch/pin merge takes every bit from the wrong source. An error in the data latch shows on `pin_out` and on the read of output bits in the cycle after the write.

Errors in the mode decode do not need any stored state to show. A wrong decode shows as missing mirror strobes, as address pins left in tri-state, or as status values on the wrong phase or in the wrong mode. The bench probes all of these within a cycle of changing the mode.

// File: rtl/mpx_port_pkg.sv
package mpx_port_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_EXPANDED = 2'd1,
    MODE_EMUL     = 2'd2,
    MODE_TEST     = 2'd3
  } port_mode_e;

  localparam int unsigned NOACC_BIT = 6;
  localparam int unsigned IQ_W      = 4;

  function automatic logic is_expanded(input logic [1:0] m);
    return m != MODE_SINGLE;
  endfunction

  function automatic logic is_emul(input logic [1:0] m);
    return m == MODE_EMUL;
  endfunction

  function automatic logic vis_capable(input logic [1:0] m);
    return (m == MODE_EMUL) || (m == MODE_TEST);
  endfunction
endpackage

// File: rtl/mpx_port_regs.sv
module mpx_port_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] dir_q
);
  logic [DATA_W-1:0] data_d, dir_d;
  logic              data_ce, dir_ce;

  always_comb begin
    data_ce = wr_en && !wr_sel;
    dir_ce  = wr_en &&  wr_sel;
    data_d  = wr_data;
    dir_d   = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (data_ce) data_q <= data_d;
      if (dir_ce)  dir_q  <= dir_d;
    end
  end

  // R12
  data_wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (data_q == $past(wr_data)));
  // R12
  dir_wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (dir_q == $past(wr_data)));
  // R1
  dir_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> $stable(dir_q));
endmodule

// File: rtl/mpx_port_pinmux.sv
module mpx_port_pinmux
  import mpx_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              vis_en,
  input  logic              phase,
  input  logic [DATA_W-1:0] data_q,
  input  logic [DATA_W-1:0] dir_q,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              noacc,
  input  logic [IQ_W-1:0]   iq_stat,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe,
  output logic              pin7_wait
);
  logic              bus_owned;
  logic              show_status;
  logic [ADDR_W-1:0] addr_pins;

  always_comb begin
    bus_owned   = is_expanded(mode);
    show_status = vis_capable(mode) && vis_en && phase;
  end

  for (genvar i = 0; i < ADDR_W; i++) begin : g_addr_pin
    if (i < IQ_W) begin : g_iq
      assign addr_pins[i] = show_status ? iq_stat[i] : ext_addr[i];
    end else if (i == NOACC_BIT) begin : g_noacc
      assign addr_pins[i] = show_status ? noacc : ext_addr[i];
    end else begin : g_plain
      assign addr_pins[i] = ext_addr[i];
    end
  end

  always_comb begin
    if (bus_owned) begin
      pin_out = {1'b0, addr_pins};
      pin_oe  = {1'b0, {ADDR_W{1'b1}}};
    end else begin
      pin_out = data_q;
      pin_oe  = dir_q;
    end
    pin7_wait = bus_owned & pin_in[DATA_W-1];
  end

  // R8
  addr_oe_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |-> (&pin_oe[ADDR_W-1:0] && !pin_oe[DATA_W-1]));
  // R2
  gpio_oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (pin_oe == dir_q && pin_out == data_q));
  // R10
  exp_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (pin_out[ADDR_W-1:0] == ext_addr));
endmodule

// File: rtl/mpx_port_rdmux.sv
module mpx_port_rdmux
  import mpx_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [1:0]        mode,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] data_q,
  input  logic [DATA_W-1:0] dir_q,
  input  logic [DATA_W-1:0] pin_in,
  input  logic [DATA_W-1:0] ext_rd_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] merged;

  always_comb begin
    merged = (dir_q & data_q) | (~dir_q & pin_in);
    if (is_emul(mode))  rd_data = ext_rd_data;
    else if (rd_sel)    rd_data = dir_q;
    else                rd_data = merged;
  end
endmodule

// File: rtl/mpx_port.sv
module mpx_port
  import mpx_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              vis_en,
  input  logic              phase,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] ext_rd_data,
  output logic              ext_wr_en,
  output logic              ext_wr_sel,
  output logic [DATA_W-1:0] ext_wr_data,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              noacc,
  input  logic [IQ_W-1:0]   iq_stat,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe,
  output logic              pin7_wait
);
  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  logic [DATA_W-1:0] data_q, dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  always_comb begin
    ext_wr_en   = bus_we && is_emul(mode);
    ext_wr_sel  = bus_sel;
    ext_wr_data = bus_wdata;
  end

  mpx_port_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(bus_we), .wr_sel(bus_sel),
    .wr_data(bus_wdata), .data_q(data_q), .dir_q(dir_q)
  );

  mpx_port_pinmux #(.DATA_W(DATA_W)) u_pinmux (
    .clk(clk), .rst_n(rst_n_s), .mode(mode), .vis_en(vis_en), .phase(phase),
    .data_q(data_q), .dir_q(dir_q), .ext_addr(ext_addr), .noacc(noacc),
    .iq_stat(iq_stat), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin7_wait(pin7_wait)
  );

  mpx_port_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .mode(mode), .rd_sel(bus_sel), .data_q(data_q), .dir_q(dir_q),
    .pin_in(pin_in), .ext_rd_data(ext_rd_data), .rd_data(bus_rdata)
  );

  // R6
  mirror_on_emul_wr_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_we && mode == 2'd2) |-> (ext_wr_en && ext_wr_data == bus_wdata));
  // R7
  no_mirror_outside_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode != 2'd2) |-> !ext_wr_en);
  // R5
  emul_read_src_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == 2'd2) |-> (bus_rdata == ext_rd_data));
endmodule

// File: tb/mpx_port_tb.sv
module mpx_port_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       vis_en, phase, bus_sel, bus_we, noacc;
  logic [7:0] bus_wdata, bus_rdata, ext_rd_data, ext_wr_data;
  logic       ext_wr_en, ext_wr_sel, pin7_wait;
  logic [6:0] ext_addr;
  logic [3:0] iq_stat;
  logic [7:0] pin_in, pin_out, pin_oe;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mpx_port u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .vis_en(vis_en), .phase(phase),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_rd_data(ext_rd_data), .ext_wr_en(ext_wr_en), .ext_wr_sel(ext_wr_sel),
    .ext_wr_data(ext_wr_data), .ext_addr(ext_addr), .noacc(noacc), .iq_stat(iq_stat),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin7_wait(pin7_wait)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    bus_sel = sel;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    mode = 2'd0; pin_in = 8'hA5;
    #1 check("R1 oe", pin_oe, 8'h00);
    rd(1'b1, v); check("R1 dir read", v, 8'h00);
    rd(1'b0, v); check("R1 data read", v, 8'hA5);
  endtask

  task automatic t_gpio;
    logic [7:0] v;
    wr(1'b1, 8'h0F); wr(1'b0, 8'h3C);
    pin_in = 8'hF0;
    #1 check("R2 oe", pin_oe, 8'h0F);
    check("R2 out", pin_out, 8'h3C);
    rd(1'b0, v); check("R3 merge a", v, 8'hFC);
    rd(1'b1, v); check("R4 dir", v, 8'h0F);
    wr(1'b1, 8'hAA); wr(1'b0, 8'h55);
    pin_in = 8'h0F;
    rd(1'b0, v); check("R3 merge b", v, 8'h05);
    check("R2 oe b", pin_oe, 8'hAA);
  endtask

  task automatic t_expanded;
    logic [7:0] v;
    wr(1'b1, 8'h00);
    mode = 2'd1; ext_addr = 7'h5A; vis_en = 1'b0; phase = 1'b0;
    pin_in = 8'h80;
    #1 check("R8 oe", pin_oe, 8'h7F);
    check("R8 addr", {1'b0, pin_out[6:0]}, 8'h5A);
    check("R11 wait", {7'd0, pin7_wait}, 8'h01);
    vis_en = 1'b1; phase = 1'b1; noacc = 1'b1; iq_stat = 4'hF;
    #1 check("R10 vis ignored", {1'b0, pin_out[6:0]}, 8'h5A);
    @(negedge clk);
    bus_sel = 1'b0; bus_wdata = 8'h77; bus_we = 1'b1;
    #1 check("R7 no mirror", {7'd0, ext_wr_en}, 8'h00);
    @(negedge clk); bus_we = 1'b0;
    pin_in = 8'h00;
    rd(1'b1, v); check("R4 dir exp", v, 8'h00);
  endtask

  task automatic t_vis;
    mode = 2'd3; vis_en = 1'b1; ext_addr = 7'h2A; noacc = 1'b1; iq_stat = 4'h9;
    phase = 1'b0;
    #1 check("R9 phase0", {1'b0, pin_out[6:0]}, 8'h2A);
    phase = 1'b1;
    #1 check("R9 phase1", {1'b0, pin_out[6:0]}, 8'h69);
    check("R11 pin7 in", {7'd0, pin_oe[7]}, 8'h00);
    vis_en = 1'b0;
    #1 check("R9 vis off", {1'b0, pin_out[6:0]}, 8'h2A);
  endtask

  task automatic t_emul;
    logic [7:0] v;
    mode = 2'd2; ext_rd_data = 8'hC3; vis_en = 1'b1; phase = 1'b1;
    #1 check("R9 emul phase1", {1'b0, pin_out[6:0]}, 8'h69);
    rd(1'b0, v); check("R5 data", v, 8'hC3);
    rd(1'b1, v); check("R5 dir", v, 8'hC3);
    @(negedge clk);
    bus_sel = 1'b1; bus_wdata = 8'hFF; bus_we = 1'b1;
    #1 check("R6 en", {7'd0, ext_wr_en}, 8'h01);
    check("R6 sel", {7'd0, ext_wr_sel}, 8'h01);
    check("R6 data", ext_wr_data, 8'hFF);
    @(negedge clk); bus_we = 1'b0;
    #1 check("R6 en drop", {7'd0, ext_wr_en}, 8'h00);
  endtask

  task automatic t_persist;
    logic [7:0] v;
    mode = 2'd0; pin_in = 8'h00;
    rd(1'b1, v); check("R12 dir kept", v, 8'hFF);
    rd(1'b0, v); check("R12 data kept", v, 8'h77);
    check("R11 pin7 gpio oe", {7'd0, pin_oe[7]}, 8'h01);
    check("R11 wait idle", {7'd0, pin7_wait}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; mode = 2'd0; vis_en = 1'b0; phase = 1'b0; bus_sel = 1'b0;
    bus_we = 1'b0; bus_wdata = 8'h00; ext_rd_data = 8'h00; ext_addr = 7'h00;
    noacc = 1'b0; iq_stat = 4'h0; pin_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_gpio();
    t_expanded();
    t_vis();
    t_emul();
    t_persist();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule